// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block is the device-side column logic of a four-bank synchronous DRAM with a 32-bit data path. A READ or WRITE command names a bank and a starting column. The block then steps through a burst of a fixed length, set by a parameter to 4 or 8 words. Write bursts take one word per cycle, starting in the command cycle. Read bursts return words with a CAS latency of two cycles on a registered output that has its own output enable.

A registered clock-enable input can freeze the internal sequencing while a burst is in progress. When clock-enable is sampled low while the block is busy, the next internal clock edge is dropped. On a dropped edge the block ignores the command and data pins, the read word on the output stays driven, and the burst counter holds. When clock-enable is sampled high again, the block resumes on the following edge. A new command on a live edge cuts short the burst in progress. The storage is a small register array, one per bank, sized by parameters.

Top module: `sdram_burst_engine`

## Requirements
- R1: After reset data_oe_o is low, data_o is zero, no burst is in progress, the internal clock is live and every storage word is zero.
- R2: cmd_i encodes 2'b00 as no-op, 2'b01 as READ and 2'b10 as WRITE, and 2'b11 is treated as a no-op. bank_i and col_i are taken only with a READ or WRITE on a live edge.
- R3: A WRITE stores data_i on BL consecutive live edges, starting with the command edge. A high dqm_i bit k leaves byte k (bits 8k+7..8k) of the word unchanged.
- R4: The word read on each live burst edge is driven on data_o, with data_oe_o high, after the next live edge. The first word is therefore valid at the second live edge after the READ (CAS latency 2).
- R5: Word i of a burst uses the start column with its low log2(BL) bits replaced by (start + i) mod BL. The burst therefore wraps inside its aligned block.
- R6: If cke_i is sampled low on an edge while the block is busy (a burst is running, a read word is pending, or a word is on the output), the next edge is suspended.
- R7: On a suspended edge cmd_i, bank_i, col_i, dqm_i and data_i are ignored, and no storage word changes.
- R8: On a suspended edge data_o and data_oe_o keep their values.
- R9: On a suspended edge the burst counter holds, so the burst continues with the next unused column.
- R10: When cke_i is sampled high, the next edge is live.
- R11: A READ or WRITE on a live edge ends the burst in progress and starts a new one. A WRITE also drops any pending read word, so data_oe_o is low after that edge.
- R12: When the block is idle, cke_i low does not suspend anything.
- R13: Each bank has its own storage. The same column in different banks holds different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable, registered |
| cmd_i | input | 2 | Command code |
| bank_i | input | BANK_W | Bank select |
| col_i | input | COL_W | Start column |
| dqm_i | input | DW/8 | Byte mask for writes, high masks the byte |
| data_i | input | DW | Write data |
| data_o | output | DW | Read data |
| data_oe_o | output | 1 | Read data valid and driven |

## Verification
The timing of each result is as follows:
- A write word lands on the live edge where it is presented.
- A read word reaches data_o one live edge after the edge that fetched it.
- A low clock-enable affects the edge after the one that sampled it.

The bench samples the ports on the falling edge after each rising edge. A behavioural model counts live and suspended edges itself and is compared with the outputs on every cycle. The directed checks count edges from the issuing call (READ, then two cycles, then the first word) and read the ports only at those points. Suspension is checked by capturing data_o before the dropped edges and comparing it after them.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;
endpackage

// File: rtl/sdb_clk_gate.sv
module sdb_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic busy_i,
  output logic ien_o
);
  // edge k samples cke; edge k+1 is live or dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ien_o <= 1'b1;
    else         ien_o <= cke_i | ~busy_i;
  end

  assert_resume_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i |=> ien_o);
endmodule

// File: rtl/sdb_burst_ctrl.sv
module sdb_burst_ctrl
  import sdb_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 4,
  parameter int BL     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ien_i,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              acc_o,
  output logic              wr_o,
  output logic              start_wr_o,
  output logic              active_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o
);
  localparam int BLW = $clog2(BL);

  cmd_e              cmd;
  logic              is_rd, is_wr, start;
  logic              act_q, wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  base_q;
  logic [BLW-1:0]    cnt_q, off;

  assign cmd   = cmd_e'(cmd_i);
  assign is_rd = (cmd == CMD_READ);
  assign is_wr = (cmd == CMD_WRITE);
  assign start = ien_i & (is_rd | is_wr);
  assign off   = base_q[BLW-1:0] + cnt_q;

  always_comb begin
    if (start) begin
      acc_o  = 1'b1;
      wr_o   = is_wr;
      bank_o = bank_i;
      col_o  = col_i;
    end else begin
      acc_o  = ien_i & act_q;
      wr_o   = wr_q;
      bank_o = bank_q;
      col_o  = {base_q[COL_W-1:BLW], off};
    end
  end

  assign start_wr_o = start & is_wr;
  assign active_o   = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      bank_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (ien_i) begin
      if (start) begin
        act_q  <= 1'b1;
        wr_q   <= is_wr;
        bank_q <= bank_i;
        base_q <= col_i;
        cnt_q  <= BLW'(1);
      end else if (act_q) begin
        cnt_q <= cnt_q + BLW'(1);
        if (cnt_q == BLW'(BL - 1)) act_q <= 1'b0;
      end
    end
  end

  assert_cnt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i |=> $stable(cnt_q) && $stable(act_q));
  assert_wrap_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !start) |-> col_o[COL_W-1:BLW] == base_q[COL_W-1:BLW]);
endmodule

// File: rtl/sdb_bank_array.sv
module sdb_bank_array #(
  parameter int NBANK = 4,
  parameter int COL_W = 4,
  parameter int DW    = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [DW/8-1:0]          be_i,
  input  logic [$clog2(NBANK)-1:0] bank_i,
  input  logic [COL_W-1:0]         col_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o
);
  localparam int DEPTH  = 1 << COL_W;
  localparam int NBYTE  = DW / 8;
  localparam int BANK_W = $clog2(NBANK);

  logic [DW-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] cells [DEPTH];
    logic          sel;
    assign sel = we_i && (bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (sel) begin
        for (int k = 0; k < NBYTE; k++)
          if (be_i[k]) cells[col_i][8*k +: 8] <= wdata_i[8*k +: 8];
      end
    end

    assign bank_rd[b] = cells[col_i];
  end

  assign rdata_o = bank_rd[bank_i];
endmodule

// File: rtl/sdb_read_pipe.sv
module sdb_read_pipe #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ien_i,
  input  logic          rd_i,
  input  logic          flush_i,
  input  logic [DW-1:0] rdata_i,
  output logic          busy_o,
  output logic [DW-1:0] data_o,
  output logic          oe_o
);
  logic          s1_v;
  logic [DW-1:0] s1_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_d   <= '0;
      oe_o   <= 1'b0;
      data_o <= '0;
    end else if (ien_i) begin
      s1_v   <= rd_i;
      s1_d   <= rdata_i;
      oe_o   <= s1_v & ~flush_i;
      data_o <= s1_d;
    end
  end

  assign busy_o = s1_v | oe_o;

  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i |=> $stable(data_o) && $stable(oe_o));
endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sdb_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int COL_W = 4,
  parameter int DW    = 32,
  parameter int BL    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cke_i,
  input  logic [1:0]               cmd_i,
  input  logic [$clog2(NBANK)-1:0] bank_i,
  input  logic [COL_W-1:0]         col_i,
  input  logic [DW/8-1:0]          dqm_i,
  input  logic [DW-1:0]            data_i,
  output logic [DW-1:0]            data_o,
  output logic                     data_oe_o
);
  localparam int BANK_W = $clog2(NBANK);

  logic              ien, busy, pipe_busy;
  logic              acc, wr, start_wr, active;
  logic [BANK_W-1:0] acc_bank;
  logic [COL_W-1:0]  acc_col;
  logic [DW-1:0]     rdata;
  logic              we, rd;

  assign busy = active | pipe_busy;
  assign we   = acc & wr;
  assign rd   = acc & ~wr;

  sdb_clk_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cke_i  (cke_i),
    .busy_i (busy),
    .ien_o  (ien)
  );

  sdb_burst_ctrl #(.BANK_W(BANK_W), .COL_W(COL_W), .BL(BL)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ien_i      (ien),
    .cmd_i      (cmd_i),
    .bank_i     (bank_i),
    .col_i      (col_i),
    .acc_o      (acc),
    .wr_o       (wr),
    .start_wr_o (start_wr),
    .active_o   (active),
    .bank_o     (acc_bank),
    .col_o      (acc_col)
  );

  sdb_bank_array #(.NBANK(NBANK), .COL_W(COL_W), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .be_i    (~dqm_i),
    .bank_i  (acc_bank),
    .col_i   (acc_col),
    .wdata_i (data_i),
    .rdata_o (rdata)
  );

  sdb_read_pipe #(.DW(DW)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ien_i   (ien),
    .rd_i    (rd),
    .flush_i (start_wr),
    .rdata_i (rdata),
    .busy_o  (pipe_busy),
    .data_o  (data_o),
    .oe_o    (data_oe_o)
  );

  assert_no_write_susp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien |-> !we);
  assert_susp_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i && busy) |=> ##1 ($stable(data_o) && $stable(data_oe_o)));
  assert_write_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien && cmd_i == CMD_WRITE) |=> !data_oe_o);
  assert_idle_live_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !cke_i) |=> ien);
endmodule

// File: tb/sdram_burst_engine_tb.sv
`timescale 1ns/1ps
module sdram_burst_engine_tb;
  localparam int NBANK = 4;
  localparam int COL_W = 4;
  localparam int DW    = 32;
  localparam int BL    = 4;
  localparam int COLS  = 1 << COL_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke = 1'b1;
  logic [1:0]    cmd = 2'b00;
  logic [1:0]    bank = '0;
  logic [COL_W-1:0] col = '0;
  logic [3:0]    dqm = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          doe;

  int checks = 0;
  int fails  = 0;
  int cyc_cnt = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  sdram_burst_engine #(.NBANK(NBANK), .COL_W(COL_W), .DW(DW), .BL(BL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cmd_i(cmd), .bank_i(bank),
    .col_i(col), .dqm_i(dqm), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  // behavioural reference
  logic [DW-1:0] mref [NBANK*COLS];
  int   m_left, m_idx, m_base, m_bank, c_now, addr;
  bit   m_wr, m_s1v, m_oe, m_ien, busy_b, live, st, nxt_oe;
  logic [DW-1:0] m_s1d, m_do;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK*COLS; i++) mref[i] = '0;
      m_left = 0; m_idx = 0; m_base = 0; m_bank = 0; m_wr = 0;
      m_s1v = 0; m_oe = 0; m_ien = 1; m_s1d = '0; m_do = '0;
    end else begin
      busy_b = (m_left > 0) || m_s1v || m_oe;
      live   = m_ien;
      m_ien  = cke || !busy_b;
      if (live) begin
        st = (cmd == 2'b01) || (cmd == 2'b10);
        if (st) begin
          m_bank = bank; m_base = col; m_idx = 0; m_left = BL; m_wr = (cmd == 2'b10);
        end
        nxt_oe = m_s1v && !(st && cmd == 2'b10);
        m_do = m_s1d; m_oe = nxt_oe; m_s1v = 0;
        if (m_left > 0) begin
          c_now = (m_base / BL) * BL + (m_base + m_idx) % BL;
          addr  = m_bank * COLS + c_now;
          if (m_wr) begin
            for (int k = 0; k < 4; k++)
              if (!dqm[k]) mref[addr][8*k +: 8] = din[8*k +: 8];
          end else begin
            m_s1v = 1; m_s1d = mref[addr];
          end
          m_idx++; m_left--;
        end
      end
    end
  end

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: compare previous edge, then drive next inputs
  task automatic cyc(bit ck, logic [1:0] c, logic [1:0] b, int cl, logic [3:0] m, logic [DW-1:0] d);
    @(negedge clk);
    if (rst_n) begin
      chk({cur_req, " oe"}, DW'(doe), DW'(m_oe));
      if (m_oe) chk({cur_req, " data"}, dout, m_do);
    end
    cke = ck; cmd = c; bank = b; col = COL_W'(cl); dqm = m; din = d;
  endtask

  task automatic nops(int n, bit ck);
    for (int i = 0; i < n; i++) cyc(ck, 2'b00, 2'b00, 0, 4'h0, '0);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic [DW-1:0] held;

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 oe reset", DW'(doe), '0);
    chk("R1 data reset", dout, '0);
    rst_n = 1'b1;
    nops(2, 1);

    // R3 write burst bank1 col0
    cur_req = "R3";
    for (int i = 0; i < 4; i++) cyc(1, i == 0 ? 2'b10 : 2'b00, 2'd1, 0, 4'h0, 32'h1000_0000 + i);
    nops(2, 1);

    // R4 latency
    cur_req = "R4";
    cyc(1, 2'b01, 2'd1, 0, 4'h0, '0);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R4 oe after first edge", DW'(doe), '0);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R4 oe word0", DW'(doe), 1);
    chk("R4 word0", dout, 32'h1000_0000);
    nops(5, 1);

    // R5 wrap
    cur_req = "R5";
    for (int i = 0; i < 4; i++) cyc(1, i == 0 ? 2'b10 : 2'b00, 2'd1, 6, 4'h0, 32'h2000_0000 + i);
    cyc(1, 2'b01, 2'd1, 5, 4'h0, '0);
    nops(2, 1);
    chk("R5 col5 word", dout, 32'h2000_0003);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R5 col6 word", dout, 32'h2000_0000);
    nops(5, 1);

    // R13 banks
    cur_req = "R13";
    for (int i = 0; i < 4; i++) cyc(1, i == 0 ? 2'b10 : 2'b00, 2'd2, 0, 4'h0, 32'h3000_0000 + i);
    cyc(1, 2'b01, 2'd2, 0, 4'h0, '0);
    nops(2, 1);
    chk("R13 bank2 col0", dout, 32'h3000_0000);
    nops(4, 1);

    // R6 R7 R8 R9 R10 read suspend
    cur_req = "R8";
    cyc(1, 2'b01, 2'd1, 0, 4'h0, '0);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    cyc(0, 2'b00, 2'd0, 0, 4'h0, '0);
    cyc(0, 2'b01, 2'd2, 0, 4'h0, '0);
    held = dout;
    chk("R6 word1 before suspend", held, 32'h1000_0001);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R8 held word", dout, held);
    chk("R8 held oe", DW'(doe), 1);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R10 still held", dout, held);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R9 next column after resume", dout, 32'h1000_0002);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R7 suspended READ ignored", dout, 32'h1000_0003);
    nops(4, 1);

    // R7 write suspend
    cur_req = "R7";
    cyc(1, 2'b10, 2'd3, 0, 4'h0, 32'h4000_0000);
    cyc(0, 2'b00, 2'd0, 0, 4'h0, 32'h4000_0001);
    cyc(0, 2'b10, 2'd0, 9, 4'h0, 32'hDEAD_BEEF);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, 32'h5555_5555);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, 32'h4000_0002);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, 32'h4000_0003);
    nops(2, 1);
    cyc(1, 2'b01, 2'd3, 0, 4'h0, '0);
    nops(2, 1);
    chk("R7 col0", dout, 32'h4000_0000);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R7 col1", dout, 32'h4000_0001);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R7 col2 not overwritten", dout, 32'h4000_0002);
    nops(4, 1);

    // R12 idle cke low
    cur_req = "R12";
    nops(3, 0);
    cyc(0, 2'b01, 2'd1, 0, 4'h0, '0);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R12 read taken while idle", dout, 32'h1000_0000);
    nops(5, 1);

    // R11 truncation
    cur_req = "R11";
    cyc(1, 2'b01, 2'd1, 0, 4'h0, '0);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    cyc(1, 2'b01, 2'd2, 0, 4'h0, '0);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R11 old word1", dout, 32'h1000_0001);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    chk("R11 new burst word0", dout, 32'h3000_0000);
    nops(5, 1);
    cyc(1, 2'b01, 2'd1, 0, 4'h0, '0);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, '0);
    cyc(1, 2'b10, 2'd0, 12, 4'h0, 32'h6000_0000);
    chk("R11 oe before write", DW'(doe), 1);
    cyc(1, 2'b00, 2'd0, 0, 4'h0, 32'h6000_0001);
    chk("R11 write drops read", DW'(doe), 0);
    nops(4, 1);

    // R3 byte mask, R2 reserved code
    cur_req = "R3";
    cyc(1, 2'b10, 2'd0, 4, 4'b0101, 32'hFFFF_FFFF);
    nops(5, 1);
    cur_req = "R2";
    cyc(1, 2'b11, 2'd0, 4, 4'h0, 32'h1234_5678);
    nops(3, 1);
    chk("R2 reserved no read", DW'(doe), 0);
    cyc(1, 2'b01, 2'd0, 4, 4'h0, '0);
    nops(2, 1);
    chk("R3 byte mask", dout, 32'hFF00_FF00);
    nops(6, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule